// File: doc/BRIEF.md
# Baud Tick Generator

This block turns a fixed 3.6864 MHz system clock into the timing enables that one full-duplex serial channel needs. Each direction, transmit and receive, has its own five-bit rate code and its own down-counter. The counter divides the reference by a constant taken from a table of 19 standard rates, from 50 to 76,800 baud. It gives a sample enable at sixteen times the bit rate. A four-bit prescaler counts sixteen sample enables to give a bit enable.

A shared two-bit source select can hand both directions over to an external serial clock pin. A two-flop synchronizer brings the pin into the system clock domain, and its rising edges are detected. The pin can work in one of two ways. As a 16x clock, each of its edges is a sample enable and every sixteenth edge is also a bit enable. As a 1x synchronous clock, each edge is both a sample enable and a bit enable.

Each direction runs a three-state machine whose states give the active source:
- SRC_INT: internal divider.
- SRC_X16: external pin used as a 16x clock.
- SRC_X1: external pin used as a 1x clock.

The transition SELECT_CHANGE goes from any state to the decoded source whenever the two differ. It restarts the counter and the prescaler. The transition STAY keeps the current state. A rate change does not use a transition. The divider picks up the new rate at its next reload, which happens on its next sample enable.

Top module: `baud_tick_gen`

## Requirements
- R1: While rst_n is low, all four tick outputs are low, whatever the external pin does.
- R2: With source code 00, the sample ticks of a direction are exactly D clock cycles apart, where D = round(3686400 / (16 × rate)) and rate code i picks, in order from 0: 50, 75, 110, 134.5, 150, 200, 300, 600, 1050, 1200, 1800, 2000, 2400, 4800, 7200, 9600, 19200, 38400, 76800 baud. Some resulting values of D:
  - code 0: 4608
  - code 2: 2095
  - code 3: 1713
  - code 5: 1152
  - code 8: 219
  - code 15: 24
  - code 18: 3
- R3: Rate codes 19 to 31 behave exactly like code 18, with D = 3.
- R4: In internal mode and in external 16x mode, a bit tick is high only together with a sample tick, and exactly 16 sample ticks separate two bit ticks. A source change restarts this count, so the 16th sample tick after the change carries the first bit tick.
- R5: A rate code change does not shorten or stretch the period in progress. The new D applies from the next sample tick on.
- R6: The transmit and receive directions each follow only their own rate code.
- R7: With source code 01, each rising edge of the external pin gives one sample tick. That tick is high in the cycle after the third rising clock edge that follows the pin change.
- R8: With source code 10, each rising edge of the external pin gives a sample tick and a bit tick in the same cycle.
- R9: On a change to internal mode, the external pin is ignored. The first sample tick appears after the (D+1)th rising clock edge that follows the select change, so there is never a runt period.
- R10: Every tick is a single-cycle pulse. A sample tick is never high in two consecutive cycles.
- R11: Source code 11 selects the internal divider, the same as code 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 3.6864 MHz system and reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_rate_sel | input | 5 | Transmit rate code (0 to 18; higher codes act as 18) |
| rx_rate_sel | input | 5 | Receive rate code (0 to 18; higher codes act as 18) |
| clk_src_sel | input | 2 | 00 or 11 = internal divider, 01 = external 16x, 10 = external 1x |
| ext_sclk | input | 1 | External serial clock pin, asynchronous |
| tx_smp_tick | output | 1 | Transmit enable at the sampling rate |
| tx_bit_tick | output | 1 | Transmit enable at the bit rate |
| rx_smp_tick | output | 1 | Receive enable at the sampling rate |
| rx_bit_tick | output | 1 | Receive enable at the bit rate |

## Verification
The bench measures the exact distance between ticks at both ends of the rate table, at the entries that need rounding, and with out-of-range codes. An off-by-one reload would show up as D±1, and a bad clamp as some other period. It changes the rate just after a tick to catch a design that reloads at once, which would give one period of the wrong length. It switches the source while the external pin is toggling. A design that does not restart the counter on a switch, or that lets pin edges through in internal mode, would give early or extra ticks. It also checks the synchronizer latency and the count of 16 in 16x mode, where a missing flop or a wrong prescaler wrap would shift or drop bit ticks.

// File: rtl/baud_pkg.sv
package baud_pkg;

    localparam int unsigned NUM_RATES = 19;

    typedef enum logic [1:0] {
        SRC_INT = 2'd0,
        SRC_X16 = 2'd1,
        SRC_X1  = 2'd2
    } src_state_e;

    // Rate in tenths of a baud for each table index.
    function automatic int unsigned rate_x10(int unsigned idx);
        case (idx)
            0:       return 500;
            1:       return 750;
            2:       return 1100;
            3:       return 1345;
            4:       return 1500;
            5:       return 2000;
            6:       return 3000;
            7:       return 6000;
            8:       return 10500;
            9:       return 12000;
            10:      return 18000;
            11:      return 20000;
            12:      return 24000;
            13:      return 48000;
            14:      return 72000;
            15:      return 96000;
            16:      return 192000;
            17:      return 384000;
            default: return 768000;
        endcase
    endfunction

    // Rounded reference cycles per 16x sample enable.
    function automatic int unsigned rate_divisor(int unsigned ref_hz, int unsigned idx);
        longint unsigned r;
        longint unsigned q;
        r = longint'(rate_x10(idx));
        q = (longint'(ref_hz) * 10 + 8 * r) / (16 * r);
        return 32'(q);
    endfunction

    function automatic src_state_e decode_src(logic [1:0] code);
        case (code)
            2'b01:   return SRC_X16;
            2'b10:   return SRC_X1;
            default: return SRC_INT;
        endcase
    endfunction

endpackage

// File: rtl/baud_edge_sync.sv
module baud_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-1:0], pin};
        end
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/baud_dir_gen.sv
module baud_dir_gen
    import baud_pkg::*;
#(
    parameter int unsigned REF_HZ = 3686400,
    parameter int unsigned SEL_W  = 5,
    parameter int unsigned OVS    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] rate_sel,
    input  logic [1:0]       src_sel,
    input  logic             ext_rise,
    output logic             smp_tick,
    output logic             bit_tick
);
    localparam int unsigned MAX_DIV = rate_divisor(REF_HZ, 0);
    localparam int unsigned CNT_W   = $clog2(MAX_DIV + 1);
    localparam int unsigned PRE_W   = $clog2(OVS);

    src_state_e       state_q;
    src_state_e       state_want;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_load;
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_next;
    logic             pre_last;
    logic             switching;
    int unsigned      div_int;
    int unsigned      idx_eff;

    always_comb begin
        if (rate_sel > SEL_W'(NUM_RATES - 1)) begin
            idx_eff = NUM_RATES - 1;
        end else begin
            idx_eff = 32'(rate_sel);
        end
        div_int  = rate_divisor(REF_HZ, idx_eff);
        cnt_load = CNT_W'(div_int - 1);
    end

    assign state_want = decode_src(src_sel);
    assign switching  = (state_want != state_q);
    assign pre_last   = (pre_q == PRE_W'(OVS - 1));
    assign pre_next   = pre_last ? '0 : pre_q + 1'b1;

    // State register: SELECT_CHANGE or STAY
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SRC_INT;
        end else begin
            state_q <= state_want;
        end
    end

    // Counters and tick outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            pre_q    <= '0;
            smp_tick <= 1'b0;
            bit_tick <= 1'b0;
        end else if (switching) begin
            cnt_q    <= cnt_load;
            pre_q    <= '0;
            smp_tick <= 1'b0;
            bit_tick <= 1'b0;
        end else begin
            unique case (state_q)
                SRC_INT: begin
                    if (cnt_q == '0) begin
                        cnt_q    <= cnt_load;
                        pre_q    <= pre_next;
                        smp_tick <= 1'b1;
                        bit_tick <= pre_last;
                    end else begin
                        cnt_q    <= cnt_q - 1'b1;
                        smp_tick <= 1'b0;
                        bit_tick <= 1'b0;
                    end
                end
                SRC_X16: begin
                    if (ext_rise) begin
                        pre_q <= pre_next;
                    end
                    smp_tick <= ext_rise;
                    bit_tick <= ext_rise & pre_last;
                end
                SRC_X1: begin
                    smp_tick <= ext_rise;
                    bit_tick <= ext_rise;
                end
                default: begin
                    smp_tick <= 1'b0;
                    bit_tick <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
    parameter int unsigned REF_HZ    = 3686400,
    parameter int unsigned SEL_W     = 5,
    parameter int unsigned OVS       = 16,
    parameter int unsigned SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] tx_rate_sel,
    input  logic [SEL_W-1:0] rx_rate_sel,
    input  logic [1:0]       clk_src_sel,
    input  logic             ext_sclk,
    output logic             tx_smp_tick,
    output logic             tx_bit_tick,
    output logic             rx_smp_tick,
    output logic             rx_bit_tick
);
    localparam int unsigned NDIR = 2;

    logic                 ext_rise;
    logic [SEL_W-1:0]     sel_a [NDIR];
    logic [NDIR-1:0]      smp_v;
    logic [NDIR-1:0]      bit_v;

    assign sel_a[0] = tx_rate_sel;
    assign sel_a[1] = rx_rate_sel;

    baud_edge_sync #(.STAGES(SYNC_STGS)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_sclk),
        .rise  (ext_rise)
    );

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        baud_dir_gen #(
            .REF_HZ (REF_HZ),
            .SEL_W  (SEL_W),
            .OVS    (OVS)
        ) i_gen (
            .clk      (clk),
            .rst_n    (rst_n),
            .rate_sel (sel_a[d]),
            .src_sel  (clk_src_sel),
            .ext_rise (ext_rise),
            .smp_tick (smp_v[d]),
            .bit_tick (bit_v[d])
        );
    end

    assign tx_smp_tick = smp_v[0];
    assign tx_bit_tick = bit_v[0];
    assign rx_smp_tick = smp_v[1];
    assign rx_bit_tick = bit_v[1];
endmodule

// File: rtl/baud_tick_chk.sv
module baud_tick_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_smp_tick,
    input logic tx_bit_tick,
    input logic rx_smp_tick,
    input logic rx_bit_tick
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !(tx_smp_tick || tx_bit_tick || rx_smp_tick || rx_bit_tick));

    // R10
    tx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_smp_tick |=> !tx_smp_tick);

    // R10
    rx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_smp_tick |=> !rx_smp_tick);

    // R4
    tx_bit_on_smp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_bit_tick |-> tx_smp_tick);

    // R4
    rx_bit_on_smp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_bit_tick |-> rx_smp_tick);
endmodule

bind baud_tick_gen baud_tick_chk i_tick_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_smp_tick (tx_smp_tick),
    .tx_bit_tick (tx_bit_tick),
    .rx_smp_tick (rx_smp_tick),
    .rx_bit_tick (rx_bit_tick)
);

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] tx_rate_sel = '0;
    logic [4:0] rx_rate_sel = '0;
    logic [1:0] clk_src_sel = 2'b00;
    logic       ext_sclk = 1'b0;
    logic       tx_smp_tick, tx_bit_tick, rx_smp_tick, rx_bit_tick;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit counting = 1'b0;
    int n_tx_smp = 0, n_tx_bit = 0, n_rx_smp = 0, n_rx_bit = 0;

    localparam int NV = 8;
    localparam int V_CODE [NV] = '{0, 2, 3, 5, 8, 15, 18, 23};
    localparam int V_DIV  [NV] = '{4608, 2095, 1713, 1152, 219, 24, 3, 3};

    always #5 clk = ~clk;

    baud_tick_gen i_baud_tick_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_rate_sel (tx_rate_sel),
        .rx_rate_sel (rx_rate_sel),
        .clk_src_sel (clk_src_sel),
        .ext_sclk    (ext_sclk),
        .tx_smp_tick (tx_smp_tick),
        .tx_bit_tick (tx_bit_tick),
        .rx_smp_tick (rx_smp_tick),
        .rx_bit_tick (rx_bit_tick)
    );

    always @(negedge clk) begin
        if (counting) begin
            n_tx_smp += int'(tx_smp_tick);
            n_tx_bit += int'(tx_bit_tick);
            n_rx_smp += int'(rx_smp_tick);
            n_rx_bit += int'(rx_bit_tick);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit smp_of(input bit rx);
        return rx ? rx_smp_tick : tx_smp_tick;
    endfunction

    task automatic get_gap(input bit rx, output int gap);
        do @(negedge clk); while (!smp_of(rx));
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!smp_of(rx));
    endtask

    task automatic clear_counts();
        n_tx_smp = 0; n_tx_bit = 0; n_rx_smp = 0; n_rx_bit = 0;
    endtask

    task automatic pulses(input int n, input int half);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ext_sclk = 1'b1;
            repeat (half) @(negedge clk);
            ext_sclk = 1'b0;
            repeat (half - 1) @(negedge clk);
        end
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int g, g2;
        // R1: reset quiet even with pin toggling
        counting = 1'b1;
        clk_src_sel = 2'b10;
        pulses(4, 3);
        check("R1 ticks during reset", n_tx_smp + n_tx_bit + n_rx_smp + n_rx_bit, 0);
        counting = 1'b0;
        ext_sclk = 1'b0;
        clk_src_sel = 2'b00;
        @(negedge clk) rst_n = 1'b1;

        // R2 / R3: vector table walk
        for (int v = 0; v < NV; v++) begin
            tx_rate_sel = 5'(V_CODE[v]);
            rx_rate_sel = 5'(V_CODE[v]);
            get_gap(1'b0, g);
            check($sformatf("R2 R3 tx code %0d", V_CODE[v]), g, V_DIV[v]);
            get_gap(1'b1, g);
            check($sformatf("R2 R3 rx code %0d", V_CODE[v]), g, V_DIV[v]);
        end

        // R3: top code
        tx_rate_sel = 5'd31;
        get_gap(1'b0, g);
        get_gap(1'b0, g);
        check("R3 code 31", g, 3);

        // R6: independent directions
        tx_rate_sel = 5'd15;
        rx_rate_sel = 5'd14;
        get_gap(1'b0, g);
        get_gap(1'b1, g2);
        check("R6 tx gap", g, 24);
        check("R6 rx gap", g2, 32);

        // R11: source code 11 is internal
        clk_src_sel = 2'b11;
        get_gap(1'b0, g);
        check("R11 src 11 gap", g, 24);
        clk_src_sel = 2'b00;

        // R5: change just after a tick
        tx_rate_sel = 5'd18;
        get_gap(1'b0, g);
        tx_rate_sel = 5'd16;
        g = 0;
        do begin @(negedge clk); g++; end while (!tx_smp_tick);
        check("R5 period in progress", g, 3);
        g = 0;
        do begin @(negedge clk); g++; end while (!tx_smp_tick);
        check("R5 new period", g, 12);

        // R4: 16 sample ticks per bit tick (internal)
        do @(negedge clk); while (!tx_bit_tick);
        g = 0;
        do begin
            @(negedge clk);
            g += int'(tx_smp_tick);
        end while (!tx_bit_tick);
        check("R4 smp per bit internal", g, 16);

        // R7: external 16x, latency then counts
        clk_src_sel = 2'b01;
        repeat (6) @(negedge clk);
        ext_sclk = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R7 no tick at edge 2", int'(tx_smp_tick), 0);
        @(negedge clk);
        check("R7 tick at edge 3", int'(tx_smp_tick), 1);
        ext_sclk = 1'b0;
        clk_src_sel = 2'b00;
        repeat (4) @(negedge clk);
        clk_src_sel = 2'b01;
        repeat (4) @(negedge clk);
        clear_counts();
        counting = 1'b1;
        pulses(32, 4);
        counting = 1'b0;
        check("R7 smp ticks x16", n_tx_smp, 32);
        check("R7 rx smp ticks x16", n_rx_smp, 32);
        check("R4 bit ticks x16", n_tx_bit, 2);

        // R8: external 1x
        clk_src_sel = 2'b10;
        repeat (4) @(negedge clk);
        clear_counts();
        counting = 1'b1;
        pulses(10, 3);
        counting = 1'b0;
        check("R8 smp ticks x1", n_tx_smp, 10);
        check("R8 bit ticks x1", n_tx_bit, 10);
        check("R8 rx bit ticks x1", n_rx_bit, 10);

        // R9: switch to internal, pin ignored, full first period
        tx_rate_sel = 5'd0;
        rx_rate_sel = 5'd0;
        clk_src_sel = 2'b00;
        clear_counts();
        counting = 1'b1;
        pulses(20, 4);
        counting = 1'b0;
        check("R9 pin ignored after switch", n_tx_smp + n_rx_smp, 0);
        clk_src_sel = 2'b10;
        @(negedge clk);
        clk_src_sel = 2'b00;
        g = 0;
        do begin @(negedge clk); g++; end while (!tx_smp_tick);
        check("R9 first internal tick", g, 4609);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule